// File: doc/BRIEF.md
# Clock-Group Retune Sequencer

This block changes the operating point of a group of derived clocks that all hang off one PLL. A request carries a target group rate in MHz. The block looks that rate up by exact match in a preset table, which is fixed at elaboration by the `GROUP` parameter. Each table entry gives a PLL rate and one 8-bit divide value per divider register.

The block compares the entry's PLL rate with the PLL's present rate, which arrives on `cur_pll_mhz`. From that comparison it picks an order:
- If the new PLL rate is lower, the PLL is retuned first and the dividers are written afterwards.
- Otherwise the dividers are written first and the PLL is retuned last.

Divider updates go out on a simple strobe/address/data write port. The PLL retune is delegated to a separate relock sequencer through a request/done handshake that returns a result code. When the sequence ends, the block pulses `done` and reports either that result code or an invalid-rate error.

Two group variants exist. The system variant (`GROUP`=0) has sixteen dividers. The tunnel variant (`GROUP`=1) has three dividers.

Top module: `clkgrp_retune_seq`

## Requirements
- R1: A request whose rate equals no table rate of the group ends with a one-cycle `done` carrying `err_invalid`=1 and `result`=0, with no divider write and no `pll_req` in between.
- R2: When the table PLL rate of the matched entry is strictly below `cur_pll_mhz`, `pll_req` is raised before any divider write, and the divider writes start only after `pll_done`.
- R3: When the table PLL rate is greater than or equal to `cur_pll_mhz` (equality included), every divider write of the group precedes the single `pll_req` of that request.
- R4: Each valid request writes every divider of the group exactly once, one per cycle in consecutive cycles, at addresses base + 16*i in ascending i. The base is 0x180 for the system group and 0x380 for the tunnel group.
- R5: System group:
  - Rates 200/400/600/800 MHz select indices 0..3, with PLL rates 800/800/600/800.
  - Divider values per index are: 4,4,3,4 at 0x180, 0x200, 0x220 and 0x250; 4,2,1,1 at 0x190; 1 at 0x1E0; 8,8,6,8 at 0x230; 24,24,18,24 at 0x240 and 0x260; 16,16,12,16 at 0x270.
  - Every other divider (0x1A0, 0x1B0, 0x1C0, 0x1D0, 0x1F0, 0x210) is 2.
- R6: Tunnel group:
  - Rates 25/50/75/100/125/150 MHz select indices 0..5, with a PLL rate of 600 except 700 for 125 MHz.
  - Divider values are 24,12,8,6,6,4 at 0x380; 4 (5 at index 4) at 0x390; 8 (10 at index 4) at 0x3A0.
- R7: `pll_req` stays high with a steady `pll_target_mhz` (the matched table PLL rate) until `pll_done`. It is never high in a cycle that carries a divider write.
- R8: `result` on the `done` pulse of a valid request equals the `pll_result` sampled with `pll_done`, and `done` lasts exactly one cycle.
- R9: After reset, `done`, `div_wr` and `pll_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe, taken when idle |
| req_rate_mhz | input | 12 | Requested group rate in MHz |
| cur_pll_mhz | input | 12 | Present PLL rate in MHz, sampled with the request |
| done | output | 1 | One-cycle completion pulse |
| err_invalid | output | 1 | With done: requested rate not in table |
| result | output | 2 | With done: PLL relock result code (0 = ok) |
| div_wr | output | 1 | Divider write strobe |
| div_addr | output | 12 | Divider register address |
| div_data | output | 8 | Divider value |
| pll_req | output | 1 | PLL retune request, held until pll_done |
| pll_target_mhz | output | 12 | PLL rate to program |
| pll_done | input | 1 | PLL relock finished pulse |
| pll_result | input | 2 | PLL relock result code, valid with pll_done |

## Verification
The hardest situation to reach from the ports is the boundary of the ordering decision: a current PLL rate exactly equal to the table rate. That case must still take the writes-first path. The other hard situation is the tunnel entry whose PLL rate differs from all of its neighbours.

The bench sweeps every table rate of both variants against a set of current rates. That set straddles each table PLL rate and also hits it exactly. A monitor records the write count at the moment `pll_req` first rises, which separates the two orderings without any timing assumption. A responder answers the PLL handshake after a delay and with a result code that changes from run to run.

// File: rtl/clkgrp_pkg.sv
package clkgrp_pkg;

  localparam int GRP_SYS   = 0;
  localparam int GRP_TUN   = 1;
  localparam int MAX_RATES = 6;
  localparam int IDXW      = $clog2(MAX_RATES);
  localparam int STRIDE    = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PLL_PRE,
    ST_WR,
    ST_PLL_POST,
    ST_DONE
  } seq_state_t;

  function automatic int grp_ndiv(int g);
    return (g == GRP_SYS) ? 16 : 3;
  endfunction

  function automatic int grp_nrate(int g);
    return (g == GRP_SYS) ? 4 : 6;
  endfunction

  function automatic int grp_base(int g);
    return (g == GRP_SYS) ? 'h180 : 'h380;
  endfunction

  // output rate of table entry i, MHz
  function automatic int rate_of(int g, int i);
    return (g == GRP_SYS) ? (i + 1) * 200 : (i + 1) * 25;
  endfunction

  // PLL rate of table entry i, MHz
  function automatic int pll_of(int g, int i);
    if (g == GRP_SYS) return (i == 2) ? 600 : 800;
    return (i == 4) ? 700 : 600;
  endfunction

  // divide value for divider r at table entry i
  function automatic int div_of(int g, int i, int r);
    int b;
    if (g == GRP_SYS) begin
      if (r == 1) return (i == 0) ? 4 : ((i == 1) ? 2 : 1);
      case (r)
        0, 8, 10, 13: b = 4;
        6:            b = 1;
        11:           b = 8;
        12, 14:       b = 24;
        15:           b = 16;
        default:      b = 2;
      endcase
      // rows scaled by 3/4 at the 600 MHz PLL point
      if (i == 2 && b != 2 && b != 1) return (b * 3) / 4;
      return b;
    end
    case (r)
      0: begin
        case (i)
          0: return 24;
          1: return 12;
          2: return 8;
          3, 4: return 6;
          default: return 4;
        endcase
      end
      1: return (i == 4) ? 5 : 4;
      default: return (i == 4) ? 10 : 8;
    endcase
  endfunction

endpackage

// File: rtl/clkgrp_lookup.sv
module clkgrp_lookup
  import clkgrp_pkg::*;
#(
  parameter int GROUP = GRP_SYS,
  parameter int RW    = 12
) (
  input  logic [RW-1:0]   rate,
  output logic            hit,
  output logic [IDXW-1:0] idx,
  output logic [RW-1:0]   pll_mhz
);
  localparam int N = grp_nrate(GROUP);

  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = (rate == RW'(rate_of(GROUP, i)));
  end

  always_comb begin
    hit     = |match;
    idx     = '0;
    pll_mhz = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        idx     = IDXW'(i);
        pll_mhz = RW'(pll_of(GROUP, i));
      end
    end
  end

  always_comb begin
    assert_match_unique_R1: assert ($onehot0(match));
  end
endmodule

// File: rtl/clkgrp_divgen.sv
module clkgrp_divgen
  import clkgrp_pkg::*;
#(
  parameter int GROUP = GRP_SYS,
  parameter int AW    = 12,
  parameter int DW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [IDXW-1:0] idx_in,
  output logic            wr,
  output logic [AW-1:0]   addr,
  output logic [DW-1:0]   data,
  output logic            last
);
  localparam int N    = grp_ndiv(GROUP);
  localparam int CW   = (N > 1) ? $clog2(N) : 1;
  localparam int BASE = grp_base(GROUP);

  logic            active;
  logic [CW-1:0]   cnt;
  logic [IDXW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      idx_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      idx_q  <= idx_in;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      cnt    <= cnt + 1'b1;
    end
  end

  assign wr   = active;
  assign last = active && (cnt == CW'(N - 1));
  assign addr = AW'(BASE) + AW'(cnt) * AW'(STRIDE);
  assign data = DW'(div_of(GROUP, int'(idx_q), int'(cnt)));

  assert_wr_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && $past(wr)) |-> (addr == $past(addr) + AW'(STRIDE)));
  assert_start_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
endmodule

// File: rtl/clkgrp_retune_seq.sv
module clkgrp_retune_seq
  import clkgrp_pkg::*;
#(
  parameter int GROUP = GRP_SYS,
  parameter int RW    = 12,
  parameter int AW    = 12,
  parameter int DW    = 8,
  parameter int RESW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [RW-1:0]   req_rate_mhz,
  input  logic [RW-1:0]   cur_pll_mhz,
  output logic            done,
  output logic            err_invalid,
  output logic [RESW-1:0] result,
  output logic            div_wr,
  output logic [AW-1:0]   div_addr,
  output logic [DW-1:0]   div_data,
  output logic            pll_req,
  output logic [RW-1:0]   pll_target_mhz,
  input  logic            pll_done,
  input  logic [RESW-1:0] pll_result
);
  seq_state_t      state;
  logic            lk_hit;
  logic [IDXW-1:0] lk_idx;
  logic [RW-1:0]   lk_pll;
  logic [IDXW-1:0] idx_q;
  logic [RW-1:0]   tgt_q;
  logic            pre_q, err_q;
  logic [RESW-1:0] res_q;
  logic            wr_start, wr_last;
  logic [IDXW-1:0] gen_idx;
  logic            pll_lower;
  logic            wr_any, pll_any;

  clkgrp_lookup #(.GROUP(GROUP), .RW(RW)) u_lookup (
    .rate    (req_rate_mhz),
    .hit     (lk_hit),
    .idx     (lk_idx),
    .pll_mhz (lk_pll)
  );

  assign pll_lower = (lk_pll < cur_pll_mhz);
  assign gen_idx   = (state == ST_IDLE) ? lk_idx : idx_q;
  assign wr_start  = ((state == ST_IDLE) && req_valid && lk_hit && !pll_lower) ||
                     ((state == ST_PLL_PRE) && pll_done);

  clkgrp_divgen #(.GROUP(GROUP), .AW(AW), .DW(DW)) u_divgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (wr_start),
    .idx_in (gen_idx),
    .wr     (div_wr),
    .addr   (div_addr),
    .data   (div_data),
    .last   (wr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx_q <= '0;
      tgt_q <= '0;
      pre_q <= 1'b0;
      err_q <= 1'b0;
      res_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          res_q <= '0;
          if (!lk_hit) begin
            err_q <= 1'b1;
            state <= ST_DONE;
          end else begin
            err_q <= 1'b0;
            idx_q <= lk_idx;
            tgt_q <= lk_pll;
            pre_q <= pll_lower;
            state <= pll_lower ? ST_PLL_PRE : ST_WR;
          end
        end
        ST_PLL_PRE: if (pll_done) begin
          res_q <= pll_result;
          state <= ST_WR;
        end
        ST_WR: if (wr_last) state <= pre_q ? ST_DONE : ST_PLL_POST;
        ST_PLL_POST: if (pll_done) begin
          res_q <= pll_result;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // per-request event flags, kept for the ordering checks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_any  <= 1'b0;
      pll_any <= 1'b0;
    end else if (state == ST_IDLE && req_valid) begin
      wr_any  <= 1'b0;
      pll_any <= 1'b0;
    end else begin
      if (div_wr)  wr_any  <= 1'b1;
      if (pll_req) pll_any <= 1'b1;
    end
  end

  assign pll_req        = (state == ST_PLL_PRE) || (state == ST_PLL_POST);
  assign pll_target_mhz = tgt_q;
  assign done           = (state == ST_DONE);
  assign err_invalid    = done && err_q;
  assign result         = res_q;

  assert_pll_before_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PLL_PRE) |-> !wr_any);
  assert_wr_before_pll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PLL_POST) |-> wr_any);
  assert_invalid_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err_invalid |-> (!wr_any && !pll_any));
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |-> !pll_req);
  assert_target_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_req && $past(pll_req)) |-> $stable(pll_target_mhz));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/clkgrp_retune_seq_test.sv
module clkgrp_retune_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid [2];
  logic [11:0] req_rate  [2];
  logic [11:0] cur_pll   [2];
  logic        done      [2];
  logic        err       [2];
  logic [1:0]  result    [2];
  logic        div_wr    [2];
  logic [11:0] div_addr  [2];
  logic [7:0]  div_data  [2];
  logic        pll_req   [2];
  logic [11:0] pll_tgt   [2];
  logic        pll_done  [2];
  logic [1:0]  resp_code [2];

  clkgrp_retune_seq #(.GROUP(0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_rate_mhz(req_rate[0]),
    .cur_pll_mhz(cur_pll[0]), .done(done[0]), .err_invalid(err[0]), .result(result[0]),
    .div_wr(div_wr[0]), .div_addr(div_addr[0]), .div_data(div_data[0]),
    .pll_req(pll_req[0]), .pll_target_mhz(pll_tgt[0]), .pll_done(pll_done[0]),
    .pll_result(resp_code[0]));

  clkgrp_retune_seq #(.GROUP(1)) uut_tun (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_rate_mhz(req_rate[1]),
    .cur_pll_mhz(cur_pll[1]), .done(done[1]), .err_invalid(err[1]), .result(result[1]),
    .div_wr(div_wr[1]), .div_addr(div_addr[1]), .div_data(div_data[1]),
    .pll_req(pll_req[1]), .pll_target_mhz(pll_tgt[1]), .pll_done(pll_done[1]),
    .pll_result(resp_code[1]));

  int checks = 0, errors = 0;
  int mchecks = 0, merrors = 0;
  int exp_idx [2];
  int nwr [2], npll [2], wrb [2], tgt_seen [2], seq [2], dly [2];
  logic prev_req [2], prev_wr [2];

  // ---- independent expectations ----
  function automatic int ndiv(int v);  return v == 0 ? 16 : 3; endfunction
  function automatic int base(int v);  return v == 0 ? 'h180 : 'h380; endfunction
  function automatic int find_idx(int v, int rate);
    int step = (v == 0) ? 200 : 25;
    int cnt  = (v == 0) ? 4 : 6;
    if (rate <= 0 || rate % step != 0 || rate / step > cnt) return -1;
    return rate / step - 1;
  endfunction
  function automatic int exp_pll(int v, int i);
    if (v == 0) return (i == 2) ? 600 : 800;
    return (i == 4) ? 700 : 600;
  endfunction
  function automatic int exp_div(int v, int a, int i);
    if (v == 0) begin
      case (a)
        'h180, 'h200, 'h220, 'h250: return (i == 2) ? 3 : 4;
        'h190: return (i == 0) ? 4 : ((i == 1) ? 2 : 1);
        'h1E0: return 1;
        'h230: return (i == 2) ? 6 : 8;
        'h240, 'h260: return (i == 2) ? 18 : 24;
        'h270: return (i == 2) ? 12 : 16;
        default: return 2;
      endcase
    end
    case (a)
      'h380: return (i == 4) ? 6 : 600 / (25 * (i + 1));
      'h390: return (i == 4) ? 5 : 4;
      default: return (i == 4) ? 10 : 8;
    endcase
  endfunction

  // ---- monitor and PLL responder ----
  initial begin
    for (int v = 0; v < 2; v++) begin
      nwr[v] = 0; npll[v] = 0; wrb[v] = 0; tgt_seen[v] = 0; seq[v] = 0; dly[v] = 0;
      prev_req[v] = 0; prev_wr[v] = 0; pll_done[v] = 0;
    end
  end

  always @(negedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (rst_n) begin
        if (div_wr[v]) begin
          mchecks++;
          if (int'(div_addr[v]) != base(v) + 16 * seq[v]) begin
            merrors++;
            $display("FAIL R4 g%0d addr act %h exp %h", v, div_addr[v], base(v) + 16 * seq[v]);
          end
          mchecks++;
          if (int'(div_data[v]) != exp_div(v, int'(div_addr[v]), exp_idx[v])) begin
            merrors++;
            $display("FAIL %s g%0d data@%h act %0d exp %0d", v == 0 ? "R5" : "R6", v,
                     div_addr[v], div_data[v], exp_div(v, int'(div_addr[v]), exp_idx[v]));
          end
          seq[v]++; nwr[v]++;
        end else if (prev_wr[v] && seq[v] < ndiv(v)) begin
          mchecks++; merrors++;
          $display("FAIL R4 g%0d write gap after %0d act gap exp none", v, seq[v]);
        end
        prev_wr[v] = div_wr[v];
        if (pll_req[v] && !prev_req[v]) begin
          npll[v]++; wrb[v] = seq[v]; tgt_seen[v] = int'(pll_tgt[v]);
        end
        prev_req[v] = pll_req[v];
        if (pll_done[v]) begin
          pll_done[v] = 1'b0;
        end else if (pll_req[v]) begin
          dly[v]++;
          if (dly[v] >= 3 + v) begin pll_done[v] = 1'b1; dly[v] = 0; end
        end
        if (done[v]) seq[v] = 0;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic run(int v, int rate, int cur, int code);
    int idx = find_idx(v, rate);
    int w0 = nwr[v], p0 = npll[v], k = 0;
    bit lower;
    exp_idx[v] = (idx < 0) ? 0 : idx;
    resp_code[v] = 2'(code);
    @(negedge clk);
    req_valid[v] = 1'b1; req_rate[v] = 12'(rate); cur_pll[v] = 12'(cur);
    @(negedge clk);
    req_valid[v] = 1'b0;
    while (!done[v] && k < 400) begin @(negedge clk); k++; end
    check("R8 done seen", int'(done[v]), 1);
    if (idx < 0) begin
      check("R1 err", int'(err[v]), 1);
      check("R1 result", int'(result[v]), 0);
      check("R1 writes", nwr[v] - w0, 0);
      check("R1 pll reqs", npll[v] - p0, 0);
    end else begin
      lower = exp_pll(v, idx) < cur;
      check("R1 err", int'(err[v]), 0);
      check("R8 result", int'(result[v]), code);
      check("R4 write count", nwr[v] - w0, ndiv(v));
      check("R7 pll reqs", npll[v] - p0, 1);
      check(v == 0 ? "R5 pll target" : "R6 pll target", tgt_seen[v], exp_pll(v, idx));
      if (lower) check("R2 writes before pll", wrb[v], 0);
      else       check("R3 writes before pll", wrb[v], ndiv(v));
    end
    @(negedge clk);
    check("R8 done one cycle", int'(done[v]), 0);
  endtask

  bit finished = 0;

  initial begin
    for (int v = 0; v < 2; v++) begin
      req_valid[v] = 0; req_rate[v] = 0; cur_pll[v] = 0; resp_code[v] = 0; exp_idx[v] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      check("R9 done", int'(done[v]), 0);
      check("R9 div_wr", int'(div_wr[v]), 0);
      check("R9 pll_req", int'(pll_req[v]), 0);
    end
    // system group: every rate against currents around and at each PLL rate
    for (int r = 1; r <= 4; r++)
      for (int c = 0; c < 5; c++)
        run(0, r * 200, 500 + 100 * c, (r + c) % 4);
    run(0, 0, 800, 1);
    run(0, 100, 800, 2);
    run(0, 250, 600, 3);
    run(0, 801, 900, 1);
    run(0, 4095, 500, 2);
    // tunnel group
    for (int r = 1; r <= 6; r++)
      for (int c = 0; c < 4; c++)
        run(1, r * 25, 600 + 50 * c, (r * 3 + c) % 4);
    run(1, 30, 600, 1);
    run(1, 200, 700, 3);
    run(1, 175, 500, 2);
    finished = 1;
    checks += mchecks;
    errors += merrors;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks += mchecks + 1;
      errors += merrors + 1;
      $display("FAIL watchdog act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule